// File: doc/BRIEF.md
# Seven-Segment Display Register Bank

This block is the bus-facing register file of a six-digit seven-segment display core. A host reaches it over a simple synchronous bus: a 2-bit register select, separate read and write strobes, and 32-bit write and read data. Two registers can be written: a value word that holds the number to show, and a mode word that holds the display switches. Two further locations are read-only. One returns a capability word built from synthesis-time parameters. The other returns a fixed identification constant.

The value word and the four mode bits go straight out to a separate display formatter, which does the segment encoding. Each optional display feature (decimal output, signed display, leading-zero blanking) is a build parameter. A mode bit whose feature is not built in cannot be set. The bus has no wait states and no back-pressure. Every strobe is accepted in the cycle it is presented.

Top module: `segbank_regs`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the value word, the mode bits and `bus_rdata` are all cleared to zero.
- R2: A write to select 0 stores all 32 bits of `bus_wdata` as the value word. A later read of select 0 returns that word.
- R3: A write to select 1 stores mode bits [3:0], using bit 0 = lamps on, bit 1 = decimal, bit 2 = blank leading zeros and bit 3 = signed. Bits [31:4] are not stored and read as zero. The mode bits change only on a write to select 1.
- R4: A read of select 2 returns the capability word: implementer ID in [31:24], core revision in [23:16], lamp configuration flag in [3], blanking support in [2], signed support in [1], decimal support in [0], and zero elsewhere.
- R5: A read of select 3 always returns 0xF708900C.
- R6: Writes to select 2 or 3 change neither the value word nor the mode bits.
- R7: Read data appears on `bus_rdata` in the cycle after the read strobe. In any cycle that follows a cycle with no read strobe, `bus_rdata` is zero.
- R8: When read and write strobes are both high in the same cycle, the write takes effect and the read returns the register contents from before that write.
- R9: `disp_value` and `disp_mode` show the stored value word and mode bits, and update in the cycle after the write.
- R10: A mode bit whose feature was not built in ignores writes and reads as zero. This covers the decimal bit, the signed bit and the blanking bit. The lamps-on bit is always writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 value, 1 mode, 2 capabilities, 3 identifier |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero when no read is pending |
| disp_value | output | 32 | Stored value word for the display formatter |
| disp_mode | output | 4 | Stored mode bits for the display formatter |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. Read data follows one cycle after the read strobe. The display outputs follow one cycle after the write, and a simultaneous write does not disturb the read result. The bench drives the strobes on the falling edge. Its behavioural model takes its snapshot at the rising edge. The outputs are compared with that model at the next falling edge, so each comparison lands on the cycle the result is due. Two instances with different feature sets share the same bus, so the bits that exist only in some builds are observed in both states.

// File: rtl/segbank_pkg.sv
package segbank_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [SEL_W-1:0] {
    REG_VALUE = 2'd0,
    REG_MODE  = 2'd1,
    REG_CAPS  = 2'd2,
    REG_IDENT = 2'd3
  } reg_sel_e;

  // mode bit positions (decoded by the display formatter)
  localparam int unsigned MB_LAMP  = 0;
  localparam int unsigned MB_DEC   = 1;
  localparam int unsigned MB_BLANK = 2;
  localparam int unsigned MB_SIGN  = 3;

  localparam logic [WORD_W-1:0] IDENT_WORD = 32'hF708_900C;
endpackage

// File: rtl/segbank_wmask.sv
module segbank_wmask
  import segbank_pkg::*;
#(
  parameter bit HAS_DEC = 1'b1,
  parameter bit HAS_SGN = 1'b1,
  parameter bit HAS_BLK = 1'b1
) (
  output logic [MODE_W-1:0] wmask
);
  localparam logic [MODE_W-1:0] AVAIL = {HAS_SGN, HAS_BLK, HAS_DEC, 1'b1};

  for (genvar b = 0; b < MODE_W; b++) begin : g_bit
    if (AVAIL[b]) begin : g_on
      assign wmask[b] = 1'b1;
    end else begin : g_off
      assign wmask[b] = 1'b0;
    end
  end
endmodule

// File: rtl/segbank_caps.sv
module segbank_caps
  import segbank_pkg::*;
#(
  parameter logic [7:0] IMPL_ID  = 8'd1,
  parameter logic [7:0] CORE_REV = 8'd0,
  parameter bit         LAMP_CFG = 1'b0,
  parameter bit         HAS_DEC  = 1'b1,
  parameter bit         HAS_SGN  = 1'b1,
  parameter bit         HAS_BLK  = 1'b1
) (
  output logic [WORD_W-1:0] caps_word
);
  localparam int unsigned PAD_W = WORD_W - 16 - 4;
  assign caps_word = {IMPL_ID, CORE_REV, {PAD_W{1'b0}},
                      LAMP_CFG, HAS_BLK, HAS_SGN, HAS_DEC};
endmodule

// File: rtl/segbank_store.sv
module segbank_store
  import segbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_value,
  input  logic              wr_mode,
  input  logic [WORD_W-1:0] wdata,
  input  logic [MODE_W-1:0] wmask,
  output logic [WORD_W-1:0] value_q,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      mode_q  <= '0;
    end else begin
      if (wr_value) value_q <= wdata;
      if (wr_mode)  mode_q  <= wdata[MODE_W-1:0] & wmask;
    end
  end

  assert_rst_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (value_q == '0 && mode_q == '0));

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q));

  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~wmask) == '0);
endmodule

// File: rtl/segbank_readout.sv
module segbank_readout
  import segbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] value_q,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [WORD_W-1:0] caps_word,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] pick;

  always_comb begin
    case (sel)
      REG_VALUE: pick = value_q;
      REG_MODE:  pick = {{(WORD_W-MODE_W){1'b0}}, mode_q};
      REG_CAPS:  pick = caps_word;
      default:   pick = IDENT_WORD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rdata <= '0;
    else if (rd)  rdata <= pick;
    else          rdata <= '0;
  end

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> rdata == '0);

  assert_ident_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == REG_IDENT) |=> rdata == IDENT_WORD);
endmodule

// File: rtl/segbank_regs.sv
module segbank_regs
  import segbank_pkg::*;
#(
  parameter logic [7:0] IMPL_ID  = 8'd1,
  parameter logic [7:0] CORE_REV = 8'd0,
  parameter bit         LAMP_CFG = 1'b0,
  parameter bit         HAS_DEC  = 1'b1,
  parameter bit         HAS_SGN  = 1'b1,
  parameter bit         HAS_BLK  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [31:0] disp_value,
  output logic [3:0]  disp_mode
);
  logic [MODE_W-1:0] wmask;
  logic [WORD_W-1:0] caps_word;
  logic              wr_value, wr_mode;

  assign wr_value = bus_wr && (bus_addr == REG_VALUE);
  assign wr_mode  = bus_wr && (bus_addr == REG_MODE);

  segbank_wmask #(.HAS_DEC(HAS_DEC), .HAS_SGN(HAS_SGN), .HAS_BLK(HAS_BLK))
    u_wmask (.wmask(wmask));

  segbank_caps #(.IMPL_ID(IMPL_ID), .CORE_REV(CORE_REV), .LAMP_CFG(LAMP_CFG),
                 .HAS_DEC(HAS_DEC), .HAS_SGN(HAS_SGN), .HAS_BLK(HAS_BLK))
    u_caps (.caps_word(caps_word));

  segbank_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_value(wr_value), .wr_mode(wr_mode),
    .wdata(bus_wdata), .wmask(wmask), .value_q(disp_value), .mode_q(disp_mode));

  segbank_readout u_readout (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(bus_addr),
    .value_q(disp_value), .mode_q(disp_mode), .caps_word(caps_word),
    .rdata(bus_rdata));

  assert_ro_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[1]) |=> ($stable(disp_value) && $stable(disp_mode)));

  assert_rw_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr && bus_addr == REG_VALUE) |=> bus_rdata == $past(disp_value));
endmodule

// File: tb/test_segbank_regs.sv
`timescale 1ns/1ps
module test_segbank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b, dval_a, dval_b;
  logic [3:0]  dmode_a, dmode_b;

  int checks = 0, errs = 0;
  bit armed = 1'b0;

  always #10 clk = ~clk;

  // instance A: every option built in; instance B: decimal and signed absent
  segbank_regs #(.IMPL_ID(8'h2A), .CORE_REV(8'h03), .LAMP_CFG(1'b1),
                 .HAS_DEC(1'b1), .HAS_SGN(1'b1), .HAS_BLK(1'b1)) i_segbank_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .disp_value(dval_a), .disp_mode(dmode_a));

  segbank_regs #(.IMPL_ID(8'h07), .CORE_REV(8'h00), .LAMP_CFG(1'b0),
                 .HAS_DEC(1'b0), .HAS_SGN(1'b0), .HAS_BLK(1'b1)) i_segbank_regs_min (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .disp_value(dval_b), .disp_mode(dmode_b));

  // behavioural model
  localparam logic [31:0] CAPS_A = 32'h2A03_000F;
  localparam logic [31:0] CAPS_B = 32'h0700_0004;
  localparam logic [31:0] IDENT  = 32'd4144533516;
  logic [31:0] m_val, m_modea, m_modeb, exp_a, exp_b;
  string tag_a, tag_b;

  function automatic logic [31:0] sel_word(input logic [1:0] a, input logic [31:0] v,
                                           input logic [31:0] md, input logic [31:0] cp);
    case (a)
      2'd0: return v;
      2'd1: return md;
      2'd2: return cp;
      default: return IDENT;
    endcase
  endfunction

  function automatic string sel_tag(input logic [1:0] a, input bit is_b);
    case (a)
      2'd0: return "R2";
      2'd1: return is_b ? "R10" : "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    armed = 1'b1;
    if (!rst_n) begin
      m_val = 0; m_modea = 0; m_modeb = 0; exp_a = 0; exp_b = 0;
      tag_a = "R1"; tag_b = "R1";
    end else begin
      if (bus_rd) begin
        exp_a = sel_word(bus_addr, m_val, m_modea, CAPS_A);
        exp_b = sel_word(bus_addr, m_val, m_modeb, CAPS_B);
        tag_a = bus_wr ? "R8" : sel_tag(bus_addr, 1'b0);
        tag_b = bus_wr ? "R8" : sel_tag(bus_addr, 1'b1);
      end else begin
        exp_a = 0; exp_b = 0; tag_a = "R7"; tag_b = "R7";
      end
      if (bus_wr && bus_addr == 2'd0) m_val = bus_wdata;
      if (bus_wr && bus_addr == 2'd1) begin
        m_modea = bus_wdata & 32'hF;
        m_modeb = bus_wdata & 32'h5;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (armed) begin
    chk(tag_a, rdata_a, exp_a);
    chk(tag_b, rdata_b, exp_b);
    chk("R9", dval_a, m_val);
    chk("R9", dval_b, m_val);
    chk("R9", {28'b0, dmode_a}, m_modea);
    chk("R10", {28'b0, dmode_b}, m_modeb);
  end

  task automatic op(input bit rd, input bit wr, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    op(0, 1, 2'd0, 32'hDEAD_BEEF);   // R2
    op(1, 0, 2'd0, 0);
    op(0, 1, 2'd1, 32'hFFFF_FFFF);   // R3 / R10
    op(1, 0, 2'd1, 0);
    op(1, 0, 2'd2, 0);               // R4
    op(1, 0, 2'd3, 0);               // R5
    op(0, 1, 2'd2, 32'h1234_5678);   // R6
    op(0, 1, 2'd3, 32'h0);
    op(0, 0, 2'd0, 0);
    @(negedge clk);
    chk("R6", dval_a, 32'hDEAD_BEEF);
    chk("R6", {28'b0, dmode_a}, 32'hF);
    op(1, 1, 2'd0, 32'h0000_0042);   // R8
    op(1, 1, 2'd1, 32'h0000_000A);   // R8, R10 decimal/signed dropped in B
    op(1, 0, 2'd1, 0);
    op(1, 0, 2'd0, 0);
    op(0, 0, 2'd0, 0);               // R7
    for (int i = 0; i < 400; i++) begin
      if (i == 200) begin
        @(negedge clk); rst_n = 1'b0; bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk); rst_n = 1'b1; // R1 mid-run
      end
      op(1'($urandom), 1'($urandom), 2'($urandom), $urandom);
    end
    op(0, 0, 2'd0, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule